// File: doc/BRIEF.md
# Host Bus Indirect Register Front End

This block sits between an 8-bit asynchronous host bus and the core of an audio synthesizer. The host sees only two byte locations, chosen by one address line. The location with the address line low holds an index. The location with the address line high is a data window onto whichever internal register the index selects. Through that window the host fills two byte queues. The immediate queue feeds the control-register and memory port directly. The deferred queue holds music data that a sequencer drains and applies at the right time. The host can also read back status, interrupt enables and interrupt pending bits.

Host strobes are asynchronous. Each bus write is brought into the core clock domain through a two-flop synchronizer and produces exactly one core-side event. The data bus is driven only while chip select and read strobe are both low. Both queue outputs are valid/ready streams. A byte leaves a queue only in a cycle where valid and ready are both high. While ready is low, valid stays high and the byte stays stable. When the consumer holds ready low, a queue fills up, and any further host writes to it are dropped and flagged.

Top module: `hbfe_top`

## Requirements
- R1: After reset the index reads 0x00, both queues are empty (status reads 0x05), `irq_n` is high, no queue output is valid, and `host_d` is high impedance.
- R2: `host_d` is driven only while `host_cs_n` and `host_rd_n` are both low. Otherwise it is high impedance.
- R3: A read with `host_a0`=0 returns the index. A read with `host_a0`=1 returns the selected register: 2 = status, 3 = interrupt enable, 4 = interrupt pending. Indices 0, 1, 5 and all other values read 0x00.
- R4: A data-window write with index 0 pushes the byte into the immediate queue. Bytes leave on `imm_data` in write order, under valid/ready.
- R5: A data-window write with index 1 pushes the byte into the deferred queue. Bytes leave on `dly_data` in write order, under valid/ready.
- R6: The index is not changed by data-window writes, so repeated data writes with index 0 or 1 push successive bytes.
- R7: A write to a full queue is dropped and sets a sticky overflow bit (status bit 4 immediate, bit 5 deferred). Writing 1 to that bit with index 2 clears it.
- R8: Status bit encoding: bit0 immediate empty, bit1 immediate full, bit2 deferred empty, bit3 deferred full, bits 4 and 5 overflow, bits 7:6 zero.
- R9: Each host access causes at most one core event. A write pushes exactly one byte however long its strobe is held. A read changes no state.
- R10: Pending bit 0 is set by writing 1 to bit 0 with index 5. Pending bit 1 is set by a one-cycle `stream_evt` pulse. Pending bits are cleared by writing 1 with index 4. Index 3 holds the enables. `irq_n` is low exactly while some pending bit is also enabled.
- R11: A write strobe with `host_cs_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_a0 | input | 1 | Selects index (0) or data window (1) |
| host_d | inout | 8 | Bidirectional host data bus |
| stream_evt | input | 1 | One-cycle stream playback event |
| imm_valid | output | 1 | Immediate queue has a byte |
| imm_data | output | 8 | Head byte of immediate queue |
| imm_ready | input | 1 | Consumer accepts immediate byte |
| dly_valid | output | 1 | Deferred queue has a byte |
| dly_data | output | 8 | Head byte of deferred queue |
| dly_ready | input | 1 | Sequencer accepts deferred byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
All 256 byte values are pushed through the immediate queue in batches, then popped and compared. This catches dropped bits, corrupted bits and reordering. Every index from 0 to 7 is written and read back through both locations, which separates the index register from the window decode. Each queue is filled to its full point and then written once more, with ready held low during part of the drain. This separates the full, drop, sticky-overflow and hold-under-back-pressure behaviours. Interrupt sources are raised with their enables on and off, which separates pending state from the `irq_n` level.

// File: rtl/hbfe_pkg.sv
package hbfe_pkg;
  localparam int DW = 8;

  localparam logic [7:0] IDX_IMM    = 8'd0;
  localparam logic [7:0] IDX_DLY    = 8'd1;
  localparam logic [7:0] IDX_STAT   = 8'd2;
  localparam logic [7:0] IDX_IEN    = 8'd3;
  localparam logic [7:0] IDX_IPEND  = 8'd4;
  localparam logic [7:0] IDX_SOFT   = 8'd5;

  localparam int NSRC = 2;

  typedef struct packed {
    logic dly_ovf;
    logic imm_ovf;
    logic dly_full;
    logic dly_empty;
    logic imm_full;
    logic imm_empty;
  } stat_t;
endpackage

// File: rtl/hbfe_sync.sv
module hbfe_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hbfe_fifo.sv
module hbfe_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a push into a full queue without a pop leaves it full, nothing overwritten
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !out_ready) |=> (full && $stable(rd_ptr)));

  // R4/R5: back-pressure keeps the head byte offered and stable
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/hbfe_top.sv
module hbfe_top #(
  parameter int IMM_DEPTH = 64,
  parameter int DLY_DEPTH = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs_n,
  input  logic       host_wr_n,
  input  logic       host_rd_n,
  input  logic       host_a0,
  inout  wire  [7:0] host_d,
  input  logic       stream_evt,
  output logic       imm_valid,
  output logic [7:0] imm_data,
  input  logic       imm_ready,
  output logic       dly_valid,
  output logic [7:0] dly_data,
  input  logic       dly_ready,
  output logic       irq_n
);
  import hbfe_pkg::*;

  logic            wr_s, wr_s_q;
  logic            hold_a0;
  logic [DW-1:0]   hold_d;
  logic            commit;
  logic [7:0]      index_q;
  logic [NSRC-1:0] ien_q, ipend_q;
  logic            imm_ovf_q, dly_ovf_q;
  logic            imm_push, dly_push;
  logic            imm_full, imm_empty, dly_full, dly_empty;
  logic            win_wr;
  stat_t           stat;
  logic [7:0]      rd_mux;

  hbfe_sync #(.WIDTH(1), .STAGES(2)) u_wr_sync (
    .clk(clk), .rst_n(rst_n),
    .din(~host_cs_n & ~host_wr_n),
    .dout(wr_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s_q  <= 1'b0;
      hold_a0 <= 1'b0;
      hold_d  <= '0;
    end else begin
      wr_s_q <= wr_s;
      if (wr_s && !wr_s_q) begin
        hold_a0 <= host_a0;
        hold_d  <= host_d;
      end
    end
  end

  assign commit   = wr_s_q && !wr_s;
  assign win_wr   = commit && hold_a0;
  assign imm_push = win_wr && (index_q == IDX_IMM);
  assign dly_push = win_wr && (index_q == IDX_DLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q   <= '0;
      ien_q     <= '0;
      ipend_q   <= '0;
      imm_ovf_q <= 1'b0;
      dly_ovf_q <= 1'b0;
    end else begin
      if (commit && !hold_a0) index_q <= hold_d;
      if (win_wr && index_q == IDX_IEN) ien_q <= hold_d[NSRC-1:0];
      if (win_wr && index_q == IDX_STAT) begin
        if (hold_d[4]) imm_ovf_q <= 1'b0;
        if (hold_d[5]) dly_ovf_q <= 1'b0;
      end
      if (imm_push && imm_full) imm_ovf_q <= 1'b1;
      if (dly_push && dly_full) dly_ovf_q <= 1'b1;
      ipend_q <= (ipend_q & ~((win_wr && index_q == IDX_IPEND) ? hold_d[NSRC-1:0] : '0))
               | {stream_evt, win_wr && index_q == IDX_SOFT && hold_d[0]};
    end
  end

  hbfe_fifo #(.DEPTH(IMM_DEPTH), .DW(DW)) u_imm_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(imm_push), .push_data(hold_d),
    .full(imm_full), .empty(imm_empty),
    .out_valid(imm_valid), .out_data(imm_data), .out_ready(imm_ready)
  );

  hbfe_fifo #(.DEPTH(DLY_DEPTH), .DW(DW)) u_dly_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(dly_push), .push_data(hold_d),
    .full(dly_full), .empty(dly_empty),
    .out_valid(dly_valid), .out_data(dly_data), .out_ready(dly_ready)
  );

  assign stat = '{dly_ovf: dly_ovf_q, imm_ovf: imm_ovf_q, dly_full: dly_full,
                  dly_empty: dly_empty, imm_full: imm_full, imm_empty: imm_empty};

  always_comb begin
    rd_mux = '0;
    if (!host_a0) begin
      rd_mux = index_q;
    end else begin
      case (index_q)
        IDX_STAT:  rd_mux = {2'b00, stat};
        IDX_IEN:   rd_mux = {{(8-NSRC){1'b0}}, ien_q};
        IDX_IPEND: rd_mux = {{(8-NSRC){1'b0}}, ipend_q};
        default:   rd_mux = '0;
      endcase
    end
  end

  assign host_d = (!host_cs_n && !host_rd_n) ? rd_mux : 8'bz;
  assign irq_n  = ~|(ipend_q & ien_q);

  // R10: stream pending rises only after a stream event
  p_stream_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipend_q[1]) |-> $past(stream_evt));

  // R7: overflow flags are sticky until a status write clears them
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(imm_ovf_q) |-> $past(win_wr && index_q == IDX_STAT));

  // R9: a host write yields a single core push per strobe
  p_single_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_push || dly_push) |=> !(imm_push || dly_push));
endmodule

// File: tb/hbfe_top_test.sv
module hbfe_top_test;
  localparam int IMM_D = 4;
  localparam int DLY_D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
  logic [7:0] tb_d = '0;
  logic tb_drv = 1'b0;
  wire  [7:0] host_d;
  logic stream_evt = 1'b0;
  logic imm_valid, dly_valid, imm_ready = 1'b0, dly_ready = 1'b0, irq_n;
  logic [7:0] imm_data, dly_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign host_d = tb_drv ? tb_d : 8'bz;
  always #5 clk = ~clk;

  hbfe_top #(.IMM_DEPTH(IMM_D), .DLY_DEPTH(DLY_D)) uut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_wr_n(wr_n),
    .host_rd_n(rd_n), .host_a0(a0), .host_d(host_d), .stream_evt(stream_evt),
    .imm_valid(imm_valid), .imm_data(imm_data), .imm_ready(imm_ready),
    .dly_valid(dly_valid), .dly_data(dly_data), .dly_ready(dly_ready),
    .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic sel, input logic [7:0] v, input int hold = 4, input bit use_cs = 1'b1);
    @(negedge clk);
    a0 = sel; tb_d = v; tb_drv = 1'b1; cs_n = !use_cs; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    tb_drv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic brd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    a0 = sel; cs_n = 1'b0; rd_n = 1'b0;
    #2 v = host_d;
    #1 rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
    bwr(1'b0, idx);
    brd(1'b1, v);
  endtask

  task automatic pop_imm(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(imm_valid === 1'b1 && imm_data === exp, tag, imm_data, exp);
    imm_ready = 1'b1;
    @(negedge clk);
    imm_ready = 1'b0;
  endtask

  task automatic pop_dly(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(dly_valid === 1'b1 && dly_data === exp, tag, dly_data, exp);
    dly_ready = 1'b1;
    @(negedge clk);
    dly_ready = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(host_d === 8'bz, "R1 bus idle z", host_d, 0);
    chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    chk(imm_valid === 1'b0 && dly_valid === 1'b0, "R1 valid low", imm_valid, 0);
    brd(1'b0, v); chk(v === 8'h00, "R1 index", v, 0);
    rd_reg(8'd2, v); chk(v === 8'h05, "R1/R8 status", v, 5);

    // R2 bus released when rd_n high with cs_n low, and vice versa
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #2;
    chk(host_d === 8'bz, "R2 cs only", host_d, 0);
    cs_n = 1'b1; rd_n = 1'b0; #2;
    chk(host_d === 8'bz, "R2 rd only", host_d, 0);
    rd_n = 1'b1;

    // R3 index sweep, both locations
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      bwr(1'b0, 8'(i));
      brd(1'b0, v); chk(v === 8'(i), "R3 index readback", v, i);
      e = (i == 2) ? 8'h05 : 8'h00;
      brd(1'b1, v); chk(v === e, "R3 window read", v, e);
    end

    // R11 write without chip select ignored
    bwr(1'b0, 8'd3);
    bwr(1'b0, 8'd6, 4, 1'b0);
    brd(1'b0, v); chk(v === 8'd3, "R11 no cs", v, 3);

    // R4 R6 R9 full sweep of byte values through immediate queue
    bwr(1'b0, 8'd0);
    for (int b = 0; b < 256; b += IMM_D) begin
      for (int k = 0; k < IMM_D; k++) bwr(1'b1, 8'((b + k) * 37 + 11));
      for (int k = 0; k < IMM_D; k++) pop_imm(8'((b + k) * 37 + 11), "R4/R6 imm order");
    end
    @(negedge clk); chk(imm_valid === 1'b0, "R4 drained", imm_valid, 0);

    // R9 long strobe pushes one byte; reads have no side effect
    bwr(1'b1, 8'hA5, 20);
    brd(1'b1, v); brd(1'b1, v); brd(1'b1, v);
    pop_imm(8'hA5, "R9 long strobe");
    @(negedge clk); chk(imm_valid === 1'b0, "R9 single push", imm_valid, 0);

    // R7 R8 immediate full and overflow
    for (int k = 0; k < IMM_D; k++) bwr(1'b1, 8'(k + 1));
    bwr(1'b0, 8'd2); brd(1'b1, v); chk(v === 8'h06, "R8 imm full", v, 6);
    bwr(1'b0, 8'd0); bwr(1'b1, 8'hEE);
    rd_reg(8'd2, v); chk(v === 8'h16, "R7 imm ovf", v, 8'h16);
    @(negedge clk); chk(imm_valid && imm_data === 8'h01, "R4 hold", imm_data, 1);
    repeat (3) @(negedge clk);
    chk(imm_valid && imm_data === 8'h01, "R4 backpressure stable", imm_data, 1);
    for (int k = 0; k < IMM_D; k++) pop_imm(8'(k + 1), "R7 drop kept order");
    @(negedge clk); chk(imm_valid === 1'b0, "R7 dropped byte absent", imm_valid, 0);
    rd_reg(8'd2, v); chk(v === 8'h15, "R7 sticky", v, 8'h15);
    bwr(1'b1, 8'h10); brd(1'b1, v); chk(v === 8'h05, "R7 clear", v, 5);

    // R5 R7 deferred queue
    bwr(1'b0, 8'd1);
    for (int k = 0; k < DLY_D; k++) bwr(1'b1, 8'(200 - 13 * k));
    chk(imm_valid === 1'b0, "R5 imm untouched", imm_valid, 0);
    rd_reg(8'd2, v); chk(v === 8'h09, "R8 dly full", v, 9);
    bwr(1'b0, 8'd1); bwr(1'b1, 8'h77);
    rd_reg(8'd2, v); chk(v === 8'h29, "R7 dly ovf", v, 8'h29);
    for (int k = 0; k < DLY_D; k++) pop_dly(8'(200 - 13 * k), "R5 dly order");
    @(negedge clk); chk(dly_valid === 1'b0, "R5 drained", dly_valid, 0);
    rd_reg(8'd2, v); chk(v === 8'h25, "R7 dly sticky", v, 8'h25);
    bwr(1'b1, 8'h20); brd(1'b1, v); chk(v === 8'h05, "R7 dly clear", v, 5);

    // R10 interrupts
    bwr(1'b0, 8'd3); bwr(1'b1, 8'h01);
    bwr(1'b0, 8'd5); bwr(1'b1, 8'h01);
    rd_reg(8'd4, v); chk(v === 8'h01, "R10 soft pending", v, 1);
    chk(irq_n === 1'b0, "R10 irq asserted", irq_n, 0);
    bwr(1'b1, 8'h01);
    rd_reg(8'd4, v); chk(v === 8'h00, "R10 w1c", v, 0);
    chk(irq_n === 1'b1, "R10 irq released", irq_n, 1);
    @(negedge clk); stream_evt = 1'b1; @(negedge clk); stream_evt = 1'b0;
    @(negedge clk);
    rd_reg(8'd4, v); chk(v === 8'h02, "R10 stream pending", v, 2);
    chk(irq_n === 1'b1, "R10 masked", irq_n, 1);
    bwr(1'b0, 8'd3); bwr(1'b1, 8'h02);
    chk(irq_n === 1'b0, "R10 enabled stream", irq_n, 0);
    rd_reg(8'd3, v); chk(v === 8'h02, "R3/R10 enable readback", v, 2);
    bwr(1'b0, 8'd4); bwr(1'b1, 8'h02);
    chk(irq_n === 1'b1, "R10 stream cleared", irq_n, 1);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      summary();
    end
  end
endmodule